// File: doc/BRIEF.md
# Automatic Level Control Gain Engine

This block scales a stream of signed audio samples by a gain that it chooses for itself. The gain tops out at 18 dB and drops when the signal gets loud, so the output does not run into its ceiling. The engine compares each sample magnitude against a ladder of levels spaced 0.5 dB apart. From the rung reached it works out a target gain code. There are two regions. In the compression region, three units of input rise give one unit of output rise. In the limiting region, gain falls dB for dB with the input until it reaches a floor of 3.5 dB.

The gain register moves toward that target in three phases. It falls quickly, by several codes per sample. It then waits for a fixed number of samples after the signal stops calling for attenuation. After that it climbs back one code at a time on a slow, fixed interval. The step sizes and intervals come from a sample-rate parameter and durations given in microseconds and milliseconds. Deasserting the enable forces full gain and clears every timer.

A four-bit selector sets the limiting threshold between 45% and 90% of full scale. The sample-rate parameter defaults to 48000.

Top module: `alc_engine`

## Requirements
- R1: Gain code c means a gain of 18 − 0.5·c dB. While `en` is low, the code is 0 on the next cycle, every sample is scaled at 18 dB, and the timers are held at zero.
- R2: `gain_code` never exceeds 29, which is 3.5 dB. At code 29, a larger input gives a larger output until saturation.
- R3: With excess count e from 0 to 36 (the compression region), the target code is floor(2·e/3).
- R4: With e greater than 36 (the limiting region), the target code is 24 + (e − 36), clamped to 29.
- R5: The threshold level is floor(32767·(45 + 3·`thr_sel`)/100) and the knee level K is that value shifted right by 4. Step level k is K·2^(k/12), computed from the mantissa table in R9. The excess count e is the number of k from 1 to 41 whose step level is at or below |x|.
- R6: On a valid sample whose target is above the current code, the code rises by min(6, target − code).
- R7: A valid sample whose target is at or above the current code, with a nonzero target, reloads a 1680-sample hold. During the hold, the code does not fall.
- R8: Once the hold has expired, the code falls by one after every 910 further valid samples whose target is below it, and never goes below the target. A sample above the code during hold or release restarts the attack and the hold.
- R9: The output is sat16((x·M(c)) >>> 12), with M(c) = (8·m[c mod 12]) >> (c div 12). The mantissa m[r] = round(4096·2^(−r/12)). Saturation is to the range −32768..32767.
- R10: The output sample and the code used to scale it appear together, one cycle after `in_vld`. After enable is reasserted, attack starts again from code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Level control enable |
| thr_sel | input | 4 | Limiting threshold select, 45% + 3% per step |
| in_vld | input | 1 | Input sample strobe |
| in_smp | input | 16 | Signed input sample |
| out_vld | output | 1 | Output sample strobe |
| out_smp | output | 16 | Gain-scaled, saturated output sample |
| gain_code | output | 5 | Current gain code, 0.5 dB per code below 18 dB |

## Verification
Each accepted sample produces its scaled output and the gain code it used one cycle later. The bench drives samples on the falling edge and reads both results on the falling edge after the last sample of a burst. Timer results are due on an exact sample count. The first release step lands on the 2590th quiet sample after the last loud one, and each later step lands 910 samples after the one before. The bench samples one sample before and exactly on each of those counts, so an off-by-one in hold or release shows as a mismatch.

// File: rtl/alc_pkg.sv
package alc_pkg;

  // Q12 mantissa of 2^(-r/12), one entry per 0.5 dB within a 6 dB octave.
  function automatic int mant12(input int r);
    case (r)
      0: return 4096;  1: return 3866;  2: return 3649;  3: return 3444;
      4: return 3251;  5: return 3069;  6: return 2896;  7: return 2734;
      8: return 2580;  9: return 2435;  10: return 2299; default: return 2170;
    endcase
  endfunction

  // Linear multiplier (Q12) for gain code c: 8x scaled down by 2^(c/12).
  function automatic int code_mult(input int c);
    return (mant12(c % 12) * 8) >> (c / 12);
  endfunction

  // Limiting threshold in sample units.
  function automatic int thr_level(input int sel, input int full);
    return (full * (45 + 3 * sel)) / 100;
  endfunction

  // Input level k half-dB steps above the knee.
  function automatic int step_level(input int knee, input int k);
    int q, r;
    q = k / 12;
    r = k % 12;
    if (r == 0) return knee << q;
    return ((knee * mant12(12 - r)) << (q + 1)) >> 12;
  endfunction

  // Target gain code from excess count: 3:1 region, then dB-for-dB, with a floor.
  function automatic int law(input int e, input int span, input int cmax);
    int t;
    if (e <= span) return (2 * e) / 3;
    t = (2 * span) / 3 + (e - span);
    return (t > cmax) ? cmax : t;
  endfunction

endpackage

// File: rtl/alc_level_det.sv
module alc_level_det #(
  parameter int SW   = 16,
  parameter int NCMP = 41,
  parameter int EW   = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [SW-1:0] smp,
  input  logic [3:0]           thr_sel,
  output logic [EW-1:0]        excess
);
  localparam int FULL = (1 << (SW - 1)) - 1;

  logic signed [SW:0] sx;
  logic [SW:0]        mag;
  int                 knee;
  logic [NCMP-1:0]    hit;

  assign sx   = {smp[SW-1], smp};
  assign mag  = sx[SW] ? $unsigned(-sx) : $unsigned(sx);
  assign knee = alc_pkg::thr_level(int'(thr_sel), FULL) >>> 4;

  for (genvar k = 1; k <= NCMP; k++) begin : g_rung
    assign hit[k-1] = (int'(mag) >= alc_pkg::step_level(knee, k));
  end

  assign excess = EW'($countones(hit));

  // Rungs rise monotonically, so hits must form a thermometer from the bottom.
  AST_LADDER_THERMO: assert property (@(posedge clk) disable iff (rst)
    ((hit & (hit + 1'b1)) == '0)); // R5

endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl #(
  parameter int CW   = 5,
  parameter int CMAX = 29,
  parameter int ATK  = 6,
  parameter int HOLD = 1680,
  parameter int REL  = 910
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          vld,
  input  logic [CW-1:0] tgt,
  output logic [CW-1:0] code_q,
  output logic [CW-1:0] code_nx
);
  localparam int HW = $clog2(HOLD + 1);
  localparam int RW = (REL > 1) ? $clog2(REL) : 1;

  logic [HW-1:0] hold_q, hold_nx;
  logic [RW-1:0] rel_q, rel_nx;
  logic          atk_ev, sus_ev, hold_busy, rel_ev;

  assign atk_ev    = en && vld && (tgt > code_q);
  assign sus_ev    = en && vld && (tgt == code_q) && (tgt != '0);
  assign hold_busy = (hold_q != '0);
  assign rel_ev    = en && vld && !atk_ev && !sus_ev && !hold_busy &&
                     (code_q != '0) && (rel_q == RW'(REL - 1));

  always_comb begin
    code_nx = code_q;
    hold_nx = hold_q;
    rel_nx  = rel_q;
    if (!en) begin
      code_nx = '0;
      hold_nx = '0;
      rel_nx  = '0;
    end else if (vld) begin
      if (atk_ev) begin
        code_nx = ((tgt - code_q) > CW'(ATK)) ? code_q + CW'(ATK) : tgt;
        hold_nx = HW'(HOLD);
        rel_nx  = '0;
      end else if (sus_ev) begin
        hold_nx = HW'(HOLD);
        rel_nx  = '0;
      end else if (hold_busy) begin
        hold_nx = hold_q - 1'b1;
      end else if (code_q != '0) begin
        if (rel_ev) begin
          code_nx = code_q - 1'b1;
          rel_nx  = '0;
        end else begin
          rel_nx = rel_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      hold_q <= '0;
      rel_q  <= '0;
    end else begin
      code_q <= code_nx;
      hold_q <= hold_nx;
      rel_q  <= rel_nx;
    end
  end

  AST_GAIN_FLOOR: assert property (@(posedge clk) disable iff (rst)
    code_q <= CW'(CMAX)); // R2
  AST_DISABLE_FULL: assert property (@(posedge clk) disable iff (rst)
    !en |=> code_q == '0); // R1
  AST_ATTACK_STEP: assert property (@(posedge clk) disable iff (rst)
    (code_q > $past(code_q)) |-> (code_q - $past(code_q) <= CW'(ATK))); // R6
  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (rst)
    (en && vld && hold_busy) |=> (!$past(en) || code_q >= $past(code_q))); // R7
  AST_RELEASE_ONE: assert property (@(posedge clk) disable iff (rst)
    (code_q < $past(code_q)) |-> (!$past(en) || ($past(code_q) - code_q == 1))); // R8

endmodule

// File: rtl/alc_scaler.sv
module alc_scaler #(
  parameter int SW = 16,
  parameter int CW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld,
  input  logic signed [SW-1:0] smp,
  input  logic [CW-1:0]        code,
  output logic                 y_vld,
  output logic signed [SW-1:0] y
);
  localparam int  MW   = 17;
  localparam int  PW   = SW + MW + 1;
  localparam logic signed [PW-1:0] YMAX = PW'((1 << (SW - 1)) - 1);
  localparam logic signed [PW-1:0] YMIN = -PW'(1 << (SW - 1));

  logic signed [MW:0]   mult;
  logic signed [PW-1:0] prod, shifted;
  logic signed [SW-1:0] sat;

  assign mult    = (MW+1)'(alc_pkg::code_mult(int'(code)));
  assign prod    = PW'(smp) * PW'(mult);
  assign shifted = prod >>> 12;

  always_comb begin
    if (shifted > YMAX)      sat = YMAX[SW-1:0];
    else if (shifted < YMIN) sat = YMIN[SW-1:0];
    else                     sat = shifted[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_vld <= 1'b0;
      y     <= '0;
    end else begin
      y_vld <= vld;
      if (vld) y <= sat;
    end
  end

  // Gain is positive and floored, so the output keeps the input's sign.
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    y_vld |-> (y[SW-1] == $past(smp[SW-1]))); // R9

endmodule

// File: rtl/alc_engine.sv
module alc_engine #(
  parameter int SW         = 16,
  parameter int SAMPLE_HZ  = 48000,
  parameter int ATTACK_US  = 100,
  parameter int HOLD_MS    = 35,
  parameter int RELEASE_MS = 550,
  parameter int CMAX       = 29,
  parameter int KNEE_SPAN  = 36
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [3:0]           thr_sel,
  input  logic                 in_vld,
  input  logic signed [SW-1:0] in_smp,
  output logic                 out_vld,
  output logic signed [SW-1:0] out_smp,
  output logic [4:0]           gain_code
);
  localparam int NCMP    = KNEE_SPAN + CMAX - (2 * KNEE_SPAN) / 3;
  localparam int EW      = $clog2(NCMP + 1);
  localparam int CW      = 5;
  localparam int ATK_RAW = (CMAX * 1000000 + (SAMPLE_HZ * ATTACK_US) / 2) / (SAMPLE_HZ * ATTACK_US);
  localparam int ATK     = (ATK_RAW < 1) ? 1 : ATK_RAW;
  localparam int HOLD    = (SAMPLE_HZ * HOLD_MS) / 1000;
  localparam int REL_RAW = ((SAMPLE_HZ * RELEASE_MS) / 1000) / CMAX;
  localparam int REL     = (REL_RAW < 1) ? 1 : REL_RAW;

  logic [EW-1:0] excess;
  logic [CW-1:0] tgt, code_q, code_nx;

  alc_level_det #(.SW(SW), .NCMP(NCMP), .EW(EW)) u_det (
    .clk(clk), .rst(rst), .smp(in_smp), .thr_sel(thr_sel), .excess(excess)
  );

  assign tgt = CW'(alc_pkg::law(int'(excess), KNEE_SPAN, CMAX));

  alc_gain_ctrl #(.CW(CW), .CMAX(CMAX), .ATK(ATK), .HOLD(HOLD), .REL(REL)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .vld(in_vld), .tgt(tgt),
    .code_q(code_q), .code_nx(code_nx)
  );

  alc_scaler #(.SW(SW), .CW(CW)) u_scl (
    .clk(clk), .rst(rst), .vld(in_vld), .smp(in_smp), .code(code_nx),
    .y_vld(out_vld), .y(out_smp)
  );

  assign gain_code = code_q;

  AST_OUT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $past(in_vld) |-> out_vld); // R10

endmodule

// File: tb/sim_alc_engine.sv
module sim_alc_engine;
  logic clk = 1'b0;
  logic rst, en, in_vld;
  logic [3:0] thr_sel;
  logic signed [15:0] in_smp;
  logic out_vld;
  logic signed [15:0] out_smp;
  logic [4:0] gain_code;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  alc_engine u0 (.clk(clk), .rst(rst), .en(en), .thr_sel(thr_sel), .in_vld(in_vld),
    .in_smp(in_smp), .out_vld(out_vld), .out_smp(out_smp), .gain_code(gain_code));

  localparam int NV = 9;
  localparam int V_SEL [NV]  = '{15, 15, 15, 15, 15, 15, 15, 0, 0};
  localparam int V_X   [NV]  = '{1000, 2256, 3796, 10719, 17039, 32767, -3796, 1000, 5000};
  localparam int V_CODE[NV]  = '{0, 2, 8, 20, 26, 29, 8, 0, 19};

  function automatic int ref_y(input int x, input int c);
    int m, g;
    longint p;
    m = $rtoi(4096.0 * (2.0 ** (-(c % 12) / 12.0)) + 0.5);
    g = (m * 8) >> (c / 12);
    p = (longint'(x) * g) >>> 12;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_n(input int x, input int n);
    @(negedge clk);
    in_vld = 1'b1;
    in_smp = 16'(x);
    repeat (n) @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    en = v;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b0; in_vld = 1'b0; in_smp = '0; thr_sel = 4'd15;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset R10 out_vld", int'(out_vld), 0);
    chk("reset R1 gain_code", int'(gain_code), 0);
    chk("reset R9 out_smp", int'(out_smp), 0);

    // Law vectors: excess count, compression and limiting regions
    for (int i = 0; i < NV; i++) begin
      set_en(1'b0);
      thr_sel = 4'(V_SEL[i]);
      set_en(1'b1);
      run_n(V_X[i], 6);
      chk($sformatf("R5 R3 R4 code vec %0d", i), int'(gain_code), V_CODE[i]);
      chk($sformatf("R9 output vec %0d", i), int'(out_smp), ref_y(V_X[i], V_CODE[i]));
    end

    // Attack rate from a fresh start
    set_en(1'b0); thr_sel = 4'd15; set_en(1'b1);
    run_n(32767, 1);
    chk("R6 first attack step", int'(gain_code), 6);
    chk("R10 out_vld with sample", int'(out_vld), 1);
    run_n(32767, 1);
    chk("R6 second attack step", int'(gain_code), 12);
    run_n(32767, 3);
    chk("R2 floor reached", int'(gain_code), 29);
    run_n(20000, 1);
    chk("R2 output at floor", int'(out_smp), 29970);
    run_n(21000, 1);
    chk("R2 output grows at floor", int'(out_smp), 31469);
    chk("R2 code stays at floor", int'(gain_code), 29);

    // Hold then release
    run_n(0, 2589);
    chk("R7 held through hold window", int'(gain_code), 29);
    run_n(0, 1);
    chk("R8 first release step", int'(gain_code), 28);
    run_n(0, 909);
    chk("R8 no early second step", int'(gain_code), 28);
    run_n(0, 1);
    chk("R8 second release step", int'(gain_code), 27);
    run_n(32767, 1);
    chk("R8 attack restarts in release", int'(gain_code), 29);
    run_n(0, 1680);
    chk("R7 hold reloaded by restart", int'(gain_code), 29);
    run_n(0, 909);
    chk("R8 release after reload not yet", int'(gain_code), 29);
    run_n(0, 1);
    chk("R8 release after reload", int'(gain_code), 28);
    run_n(0, 25479);
    chk("R8 one code left", int'(gain_code), 1);
    run_n(0, 1);
    chk("R8 full gain restored", int'(gain_code), 0);

    // Release stops at the target of a steady medium signal
    run_n(32767, 5);
    run_n(3796, 20890);
    chk("R8 release floor at target", int'(gain_code), 8);
    chk("R9 output at target code", int'(out_smp), ref_y(3796, 8));

    // Enable drop clears state; attack starts over
    set_en(1'b0);
    @(negedge clk);
    chk("R1 disable forces code 0", int'(gain_code), 0);
    set_en(1'b1);
    run_n(0, 1);
    chk("R10 quiet after re-enable", int'(gain_code), 0);
    run_n(32767, 1);
    chk("R10 attack from zero", int'(gain_code), 6);

    // Disabled: fixed 18 dB with saturation
    set_en(1'b0);
    run_n(4000, 1);
    chk("R1 disabled 18 dB", int'(out_smp), 32000);
    chk("R1 disabled code", int'(gain_code), 0);
    run_n(5000, 1);
    chk("R9 positive saturation", int'(out_smp), 32767);
    run_n(-5000, 1);
    chk("R9 negative saturation", int'(out_smp), -32768);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule